// File: doc/BRIEF.md
# Accumulator Execution Unit

This block is one execution unit of a parallel RISC machine. It owns a single accumulator register and two status flags, a carry flag and a zero flag. Each clock it takes one instruction that is already decoded into fields: a group, an operation code, a carry-type bit, three load enables and an operand-select bit. It then combines the accumulator with a second operand, or works on the accumulator alone. The second operand is either the value on a register operand input or the value on an immediate input. All values are unsigned.

Four groups exist. The arithmetic group adds, subtracts and compares, each optionally with the incoming carry. The logic group has AND, OR, XOR, NOT and a bit test. The shift group moves the accumulator by one place: plain, arithmetic and rotating shifts in both directions, including rotation through the carry flag. The unary group increments, decrements or negates the accumulator. The load enables decide, for each instruction, whether the accumulator, the carry flag and the zero flag take the new values. Each operation also limits which of them it may write.

Top module: `acc_exec_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the accumulator, CF and ZF to 0, whatever instruction is present.
- R2: Group 0 code 0 (ADD) writes acc + operand, plus CF when `with_c_i` is 1. CF becomes the carry out of the top bit.
- R3: Group 0 code 1 (SUB) writes acc - operand, minus CF when `with_c_i` is 1. CF becomes 1 when acc is less than operand plus the borrow-in.
- R4: Group 0 code 2 (CMP) sets CF and ZF exactly as SUB would. It never changes the accumulator, even with `ld_acc_i` set.
- R5: When `use_imm_i` is 1 the second operand is `imm_op_i`. When it is 0 the second operand is `reg_op_i`.
- R6: Group 1 codes 0, 1, 2 and 3 give AND, OR and XOR with the operand and NOT of the accumulator. Each of them clears CF.
- R7: Group 1 code 4 (TEST) sets ZF to 1 when acc AND operand is zero. It leaves the accumulator and CF unchanged.
- R8: Group 2 codes 0 and 1 (SHL, SAL) shift left by one and shift in 0. Code 4 (SHR) shifts right and shifts in 0. Code 5 (SAR) shifts right and keeps the top bit. CF takes the bit shifted out.
- R9: Group 2 code 2 (ROL) and code 6 (ROR) rotate by one place. Code 3 (RCL) and code 7 (RCR) rotate through CF. In all four, CF takes the bit that leaves the accumulator.
- R10: Group 3 code 0 (INC) adds 1, with CF as the carry out. Code 1 (DEC) subtracts 1, with CF as the borrow. Code 2 (NEG) writes 0 - acc, with CF set when acc is nonzero. These ignore the second operand.
- R11: When `ld_acc_i`, `ld_cf_i` or `ld_zf_i` is 0, the accumulator, CF or ZF respectively keeps its value.
- R12: When ZF is loaded, it becomes 1 exactly when the operation's result is all zeros. For CMP the result is the difference. For TEST it is the AND.
- R13: Codes that are not assigned change nothing. These are group 0 codes 3 to 7, group 1 codes 5 to 7 and group 3 codes 3 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| grp_i | input | 2 | Group: 0 arithmetic, 1 logic, 2 shift, 3 unary |
| opc_i | input | 3 | Operation code within the group |
| with_c_i | input | 1 | Use CF as carry-in or borrow-in for ADD, SUB and CMP |
| ld_acc_i | input | 1 | Load enable for the accumulator |
| ld_cf_i | input | 1 | Load enable for CF |
| ld_zf_i | input | 1 | Load enable for ZF |
| use_imm_i | input | 1 | 1 selects the immediate as second operand, 0 selects the register |
| reg_op_i | input | W | Register operand |
| imm_op_i | input | W | Immediate operand |
| acc_o | output | W | Accumulator value |
| cf_o | output | 1 | Carry flag |
| zf_o | output | 1 | Zero flag |

## Verification
Each operation is run from a known start state, with the accumulator and CF set up beforehand. The operands are chosen so that a wrong result stands out. Additions and subtractions are run with the carry-type bit both set and clear while CF holds 1, which shows whether the carry is used or ignored. They are also run at the points where the result wraps to zero or borrows, which separates a carry out from a zero result. Shift and rotate patterns have different end bits and different incoming CF values, which exposes a rotation confused with a carry rotation, and an arithmetic shift confused with a logical one. Unary and shift operations run with a nonzero decoy register operand. Load-enable, compare, bit-test and unused-code cases start from states where an update would show on the outputs.

// File: rtl/acc_eu_pkg.sv
package acc_eu_pkg;

    typedef enum logic [1:0] {
        GRP_ARITH = 2'd0,
        GRP_LOGIC = 2'd1,
        GRP_SHIFT = 2'd2,
        GRP_UNARY = 2'd3
    } grp_e;

    // arithmetic group
    localparam logic [2:0] OP_ADD  = 3'd0;
    localparam logic [2:0] OP_SUB  = 3'd1;
    localparam logic [2:0] OP_CMP  = 3'd2;
    // logic group
    localparam logic [2:0] OP_AND  = 3'd0;
    localparam logic [2:0] OP_OR   = 3'd1;
    localparam logic [2:0] OP_XOR  = 3'd2;
    localparam logic [2:0] OP_NOT  = 3'd3;
    localparam logic [2:0] OP_TEST = 3'd4;
    // shift group
    localparam logic [2:0] OP_SHL  = 3'd0;
    localparam logic [2:0] OP_SAL  = 3'd1;
    localparam logic [2:0] OP_ROL  = 3'd2;
    localparam logic [2:0] OP_RCL  = 3'd3;
    localparam logic [2:0] OP_SHR  = 3'd4;
    localparam logic [2:0] OP_SAR  = 3'd5;
    localparam logic [2:0] OP_ROR  = 3'd6;
    localparam logic [2:0] OP_RCR  = 3'd7;
    // unary group
    localparam logic [2:0] OP_INC  = 3'd0;
    localparam logic [2:0] OP_DEC  = 3'd1;
    localparam logic [2:0] OP_NEG  = 3'd2;

    // which state items an operation is allowed to write
    typedef struct packed {
        logic acc;
        logic cf;
        logic zf;
    } wr_mask_t;

    localparam wr_mask_t WR_NONE = 3'b000;
    localparam wr_mask_t WR_ALL  = 3'b111;

endpackage

// File: rtl/acc_eu_arith.sv
// Shared adder for the arithmetic group and the unary group.
module acc_eu_arith
    import acc_eu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         sel_unary,
    input  logic [2:0]   opc,
    input  logic         with_c,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output wr_mask_t     wr
);
    localparam int SW = W + 1;

    logic [W-1:0]  add_x;
    logic [W-1:0]  add_y;
    logic          add_ci;
    logic          borrow_mode;
    logic [SW-1:0] sum;

    always_comb begin
        add_x       = a;
        add_y       = '0;
        add_ci      = 1'b0;
        borrow_mode = 1'b0;
        wr          = WR_NONE;
        if (!sel_unary) begin
            case (opc)
                OP_ADD: begin
                    add_y  = b;
                    add_ci = with_c & cin;
                    wr     = WR_ALL;
                end
                OP_SUB, OP_CMP: begin
                    add_y       = ~b;
                    add_ci      = ~(with_c & cin);
                    borrow_mode = 1'b1;
                    wr          = '{acc: (opc == OP_SUB), cf: 1'b1, zf: 1'b1};
                end
                default: wr = WR_NONE;
            endcase
        end else begin
            case (opc)
                OP_INC: begin
                    add_ci = 1'b1;
                    wr     = WR_ALL;
                end
                OP_DEC: begin
                    add_y       = '1;
                    borrow_mode = 1'b1;
                    wr          = WR_ALL;
                end
                OP_NEG: begin
                    add_x       = '0;
                    add_y       = ~a;
                    add_ci      = 1'b1;
                    borrow_mode = 1'b1;
                    wr          = WR_ALL;
                end
                default: wr = WR_NONE;
            endcase
        end
    end

    assign sum  = {1'b0, add_x} + {1'b0, add_y} + {{(SW-1){1'b0}}, add_ci};
    assign res  = sum[W-1:0];
    assign cout = sum[W] ^ borrow_mode;

endmodule

// File: rtl/acc_eu_logic.sv
// Bitwise operations and bit test.
module acc_eu_logic
    import acc_eu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]   opc,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res,
    output logic         cout,
    output wr_mask_t     wr
);
    always_comb begin
        res  = a;
        cout = 1'b0;
        wr   = WR_ALL;
        case (opc)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            OP_TEST: begin
                res = a & b;
                wr  = '{acc: 1'b0, cf: 1'b0, zf: 1'b1};
            end
            default: wr = WR_NONE;
        endcase
    end
endmodule

// File: rtl/acc_eu_shift.sv
// Single-place shifts and rotations of the accumulator.
module acc_eu_shift
    import acc_eu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]   opc,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout,
    output wr_mask_t     wr
);
    localparam int MSB = W - 1;

    logic left_dir;
    logic fill_bit;

    always_comb begin
        left_dir = ~opc[2];
        case (opc)
            OP_SHL, OP_SAL, OP_SHR: fill_bit = 1'b0;
            OP_ROL:                 fill_bit = a[MSB];
            OP_ROR:                 fill_bit = a[0];
            OP_SAR:                 fill_bit = a[MSB];
            default:                fill_bit = cin;
        endcase
        if (left_dir) begin
            res  = {a[MSB-1:0], fill_bit};
            cout = a[MSB];
        end else begin
            res  = {fill_bit, a[MSB:1]};
            cout = a[0];
        end
        wr = WR_ALL;
    end
endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
    import acc_eu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   grp_i,
    input  logic [2:0]   opc_i,
    input  logic         with_c_i,
    input  logic         ld_acc_i,
    input  logic         ld_cf_i,
    input  logic         ld_zf_i,
    input  logic         use_imm_i,
    input  logic [W-1:0] reg_op_i,
    input  logic [W-1:0] imm_op_i,
    output logic [W-1:0] acc_o,
    output logic         cf_o,
    output logic         zf_o
);
    typedef struct packed {
        logic [W-1:0] acc;
        logic         cf;
        logic         zf;
    } state_t;

    state_t st_d, st_q;

    logic [W-1:0] opnd_b;
    logic [W-1:0] ar_res, lg_res, sh_res, sel_res;
    logic         ar_cout, lg_cout, sh_cout, sel_cout;
    wr_mask_t     ar_wr, lg_wr, sh_wr, sel_wr;
    grp_e         grp;

    assign grp    = grp_e'(grp_i);
    assign opnd_b = use_imm_i ? imm_op_i : reg_op_i;

    acc_eu_arith #(.W(W)) u_arith (
        .sel_unary (grp == GRP_UNARY),
        .opc       (opc_i),
        .with_c    (with_c_i),
        .a         (st_q.acc),
        .b         (opnd_b),
        .cin       (st_q.cf),
        .res       (ar_res),
        .cout      (ar_cout),
        .wr        (ar_wr)
    );

    acc_eu_logic #(.W(W)) u_logic (
        .opc  (opc_i),
        .a    (st_q.acc),
        .b    (opnd_b),
        .res  (lg_res),
        .cout (lg_cout),
        .wr   (lg_wr)
    );

    acc_eu_shift #(.W(W)) u_shift (
        .opc  (opc_i),
        .a    (st_q.acc),
        .cin  (st_q.cf),
        .res  (sh_res),
        .cout (sh_cout),
        .wr   (sh_wr)
    );

    always_comb begin
        case (grp)
            GRP_LOGIC: begin
                sel_res = lg_res; sel_cout = lg_cout; sel_wr = lg_wr;
            end
            GRP_SHIFT: begin
                sel_res = sh_res; sel_cout = sh_cout; sel_wr = sh_wr;
            end
            default: begin
                sel_res = ar_res; sel_cout = ar_cout; sel_wr = ar_wr;
            end
        endcase

        st_d = st_q;
        if (ld_acc_i && sel_wr.acc) st_d.acc = sel_res;
        if (ld_cf_i  && sel_wr.cf)  st_d.cf  = sel_cout;
        if (ld_zf_i  && sel_wr.zf)  st_d.zf  = (sel_res == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign acc_o = st_q.acc;
    assign cf_o  = st_q.cf;
    assign zf_o  = st_q.zf;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc_o == '0 && !cf_o && !zf_o));

    // R4
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (grp_i == GRP_ARITH && opc_i == OP_CMP) |=> (acc_o == $past(acc_o)));

    // R7
    test_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
        (grp_i == GRP_LOGIC && opc_i == OP_TEST)
            |=> (acc_o == $past(acc_o) && cf_o == $past(cf_o)));

    // R11
    hold_acc_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_acc_i |=> (acc_o == $past(acc_o)));

    // R11
    hold_cf_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_cf_i |=> (cf_o == $past(cf_o)));

    // R11
    hold_zf_chk: assert property (@(posedge clk) disable iff (rst)
        !ld_zf_i |=> (zf_o == $past(zf_o)));

    // R13
    unused_code_chk: assert property (@(posedge clk) disable iff (rst)
        ((grp_i == GRP_ARITH && opc_i > OP_CMP) ||
         (grp_i == GRP_LOGIC && opc_i > OP_TEST) ||
         (grp_i == GRP_UNARY && opc_i > OP_NEG))
            |=> (acc_o == $past(acc_o) && cf_o == $past(cf_o) && zf_o == $past(zf_o)));

endmodule

// File: tb/acc_exec_unit_test.sv
module acc_exec_unit_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   grp_i = '0;
    logic [2:0]   opc_i = '0;
    logic         with_c_i = 1'b0;
    logic         ld_acc_i = 1'b0;
    logic         ld_cf_i = 1'b0;
    logic         ld_zf_i = 1'b0;
    logic         use_imm_i = 1'b0;
    logic [W-1:0] reg_op_i = '0;
    logic [W-1:0] imm_op_i = '0;
    logic [W-1:0] acc_o;
    logic         cf_o;
    logic         zf_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    acc_exec_unit #(.W(W)) uut (.*);

    always #5 clk = ~clk;

    typedef struct packed {
        logic [1:0] grp;
        logic [2:0] opc;
        logic       wc;
        logic       la;
        logic       lc;
        logic       lz;
        logic       ui;
        logic [7:0] rop;
        logic [7:0] iop;
        logic [7:0] a0;
        logic       c0;
        logic [7:0] ea;
        logic       ec;
        logic       ez;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 35;
    // fields: grp opc wc la lc lz ui rop iop a0 c0 | ea ec ez req
    localparam vec_t VECS [NV] = '{
        '{2'd0,3'd0,1'b0,1'b1,1'b1,1'b1,1'b0,8'h14,8'hAA,8'h3C,1'b1,8'h50,1'b0,1'b0,4'd2},  // R2 carry ignored
        '{2'd0,3'd0,1'b1,1'b1,1'b1,1'b1,1'b1,8'h55,8'h0F,8'hF0,1'b1,8'h00,1'b1,1'b1,4'd2},  // R2 R12 wrap
        '{2'd0,3'd0,1'b0,1'b1,1'b1,1'b1,1'b1,8'h00,8'h80,8'h80,1'b0,8'h00,1'b1,1'b1,4'd5},  // R5 immediate
        '{2'd0,3'd1,1'b0,1'b1,1'b1,1'b1,1'b0,8'h21,8'h00,8'h20,1'b1,8'hFF,1'b1,1'b0,4'd3},  // R3 borrow
        '{2'd0,3'd1,1'b1,1'b1,1'b1,1'b1,1'b0,8'h20,8'h00,8'h21,1'b1,8'h00,1'b0,1'b1,4'd3},  // R3 with borrow-in
        '{2'd0,3'd1,1'b1,1'b1,1'b1,1'b1,1'b0,8'h10,8'h00,8'h10,1'b1,8'hFF,1'b1,1'b0,4'd3},  // R3 borrow-in causes borrow
        '{2'd0,3'd2,1'b0,1'b1,1'b1,1'b1,1'b1,8'h00,8'h05,8'h05,1'b1,8'h05,1'b0,1'b1,4'd4},  // R4 equal
        '{2'd0,3'd2,1'b0,1'b1,1'b1,1'b1,1'b1,8'h00,8'h06,8'h05,1'b0,8'h05,1'b1,1'b0,4'd4},  // R4 below
        '{2'd1,3'd0,1'b0,1'b1,1'b1,1'b1,1'b0,8'hAA,8'h00,8'hCC,1'b1,8'h88,1'b0,1'b0,4'd6},  // R6 AND
        '{2'd1,3'd1,1'b0,1'b1,1'b1,1'b1,1'b1,8'hFF,8'h30,8'h0C,1'b0,8'h3C,1'b0,1'b0,4'd5},  // R5 R6 OR
        '{2'd1,3'd2,1'b0,1'b1,1'b1,1'b1,1'b0,8'h5A,8'h00,8'h5A,1'b1,8'h00,1'b0,1'b1,4'd6},  // R6 R12 XOR
        '{2'd1,3'd3,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h0F,1'b1,8'hF0,1'b0,1'b0,4'd6},  // R6 NOT
        '{2'd1,3'd4,1'b0,1'b1,1'b1,1'b1,1'b0,8'h0F,8'h00,8'hF0,1'b1,8'hF0,1'b1,1'b1,4'd7},  // R7 R12 zero
        '{2'd1,3'd4,1'b0,1'b1,1'b1,1'b1,1'b0,8'h10,8'h00,8'hF0,1'b0,8'hF0,1'b0,1'b0,4'd7},  // R7 nonzero
        '{2'd2,3'd0,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h81,1'b0,8'h02,1'b1,1'b0,4'd8},  // R8 SHL
        '{2'd2,3'd1,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h80,1'b0,8'h00,1'b1,1'b1,4'd8},  // R8 SAL
        '{2'd2,3'd4,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h03,1'b0,8'h01,1'b1,1'b0,4'd8},  // R8 SHR
        '{2'd2,3'd5,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h82,1'b0,8'hC1,1'b0,1'b0,4'd8},  // R8 SAR top set
        '{2'd2,3'd5,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h41,1'b0,8'h20,1'b1,1'b0,4'd8},  // R8 SAR top clear
        '{2'd2,3'd2,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h81,1'b0,8'h03,1'b1,1'b0,4'd9},  // R9 ROL
        '{2'd2,3'd6,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h01,1'b0,8'h80,1'b1,1'b0,4'd9},  // R9 ROR
        '{2'd2,3'd3,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h40,1'b1,8'h81,1'b0,1'b0,4'd9},  // R9 RCL
        '{2'd2,3'd7,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h01,1'b0,8'h00,1'b1,1'b1,4'd9},  // R9 RCR cf in 0
        '{2'd2,3'd7,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h02,1'b1,8'h81,1'b0,1'b0,4'd9},  // R9 RCR cf in 1
        '{2'd3,3'd0,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'hFF,1'b0,8'h00,1'b1,1'b1,4'd10}, // R10 INC wrap
        '{2'd3,3'd0,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h41,1'b1,8'h42,1'b0,1'b0,4'd10}, // R10 INC
        '{2'd3,3'd1,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h00,1'b0,8'hFF,1'b1,1'b0,4'd10}, // R10 DEC borrow
        '{2'd3,3'd1,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h01,1'b0,8'h00,1'b0,1'b1,4'd10}, // R10 DEC to zero
        '{2'd3,3'd2,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h01,1'b0,8'hFF,1'b1,1'b0,4'd10}, // R10 NEG
        '{2'd3,3'd2,1'b0,1'b1,1'b1,1'b1,1'b0,8'hFF,8'h00,8'h00,1'b1,8'h00,1'b0,1'b1,4'd10}, // R10 NEG zero
        '{2'd0,3'd0,1'b0,1'b0,1'b1,1'b1,1'b0,8'h01,8'h00,8'hFF,1'b0,8'hFF,1'b1,1'b1,4'd11}, // R11 acc held
        '{2'd0,3'd0,1'b0,1'b1,1'b0,1'b0,1'b0,8'h01,8'h00,8'hFF,1'b0,8'h00,1'b0,1'b0,4'd11}, // R11 flags held
        '{2'd0,3'd5,1'b0,1'b1,1'b1,1'b1,1'b0,8'h11,8'h00,8'h33,1'b1,8'h33,1'b1,1'b0,4'd13}, // R13 arith code 5
        '{2'd3,3'd7,1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,8'h00,1'b0,8'h00,1'b0,1'b0,4'd13}, // R13 unary code 7
        '{2'd1,3'd6,1'b0,1'b1,1'b1,1'b1,1'b0,8'h00,8'h00,8'h00,1'b1,8'h00,1'b1,1'b0,4'd13}  // R13 logic code 6
    };

    task automatic issue(input logic [1:0] g, input logic [2:0] o, input logic wc,
                         input logic la, input logic lc, input logic lz, input logic ui,
                         input logic [7:0] rop, input logic [7:0] iop);
        grp_i = g; opc_i = o; with_c_i = wc;
        ld_acc_i = la; ld_cf_i = lc; ld_zf_i = lz;
        use_imm_i = ui; reg_op_i = rop; imm_op_i = iop;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ld_acc_i = 1'b0; ld_cf_i = 1'b0; ld_zf_i = 1'b0;
        grp_i = 2'd2; opc_i = 3'd0;
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // after reset: CF=1 via CMP 0 against 1 (if wanted), then acc via OR
    task automatic preload(input logic [7:0] a0, input logic c0);
        do_reset();
        if (c0) issue(2'd0, 3'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h00, 8'h01);
        issue(2'd1, 3'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, a0);
        idle();
    endtask

    task automatic check(input int req, input string what,
                         input logic [7:0] ea, input logic ec, input logic ez);
        checks++;
        if (acc_o !== ea || cf_o !== ec || zf_o !== ez) begin
            failures++;
            $display("FAIL R%0d %s: acc=%h cf=%b zf=%b expected acc=%h cf=%b zf=%b",
                     req, what, acc_o, cf_o, zf_o, ea, ec, ez);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: state after reset
        @(negedge clk);
        do_reset();
        check(1, "reset state", 8'h00, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            preload(VECS[i].a0, VECS[i].c0);
            issue(VECS[i].grp, VECS[i].opc, VECS[i].wc, VECS[i].la, VECS[i].lc,
                  VECS[i].lz, VECS[i].ui, VECS[i].rop, VECS[i].iop);
            idle();
            check(int'(VECS[i].req), $sformatf("vector %0d", i),
                  VECS[i].ea, VECS[i].ec, VECS[i].ez);
        end

        // R1: reset wins over a loading instruction
        preload(8'h77, 1'b1);
        grp_i = 2'd0; opc_i = 3'd0; with_c_i = 1'b1;
        ld_acc_i = 1'b1; ld_cf_i = 1'b1; ld_zf_i = 1'b1;
        use_imm_i = 1'b0; reg_op_i = 8'h12;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        idle();
        check(1, "reset during ADD", 8'h00, 1'b0, 1'b0);

        // R11: all load bits clear with a shift leaves a preloaded state
        preload(8'h81, 1'b1);
        issue(2'd2, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        idle();
        check(11, "no load bits", 8'h81, 1'b1, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule